// File: doc/BRIEF.md
# Configurable Port Input Capture Bank

The block places one capture cell behind each pin of three 8-bit input ports, 24 cells in all. Each cell passes its pin straight through, acts as a level-sensitive latch, or acts as an edge-triggered register. The result drives a 24-bit bus that feeds on-chip logic. The cells work inside one synchronous clock domain. Latch storage and register edges are sampled on the system clock.

Cells are grouped by nibble: bits 3..0 and bits 7..4 of each port. Each group shares one enable. A select bit per group takes that enable either from a dedicated logic-term input or from the processor address strobe. Address-strobe capture lets upper address bits be held as logic inputs.

Mode and source-select registers are loaded through a small write port. A processor reads any one port's eight cell outputs through a registered read port.

Top module: `port_capture_bank`

## Requirements
- R1: Cell k reads pin_in[k] and drives bus_out[k]. Port p occupies bits 8p+7..8p of both vectors.
- R2: A cell in mode 00 or mode 11 drives its pin value onto bus_out in the same cycle, with no clock delay.
- R3: A cell in mode 01 is transparent while its group enable is high. While the enable is low, it shows the pin value sampled at the last clock edge at which the enable was high.
- R4: A cell in mode 10 shows a stored value. The store loads the pin at a clock edge where the group enable is sampled high after being sampled low at the previous edge, or at the first edge after reset. At no other edge does the store change.
- R5: Group g = 2p + h covers port p, where h = 0 for bits 3..0 and h = 1 for bits 7..4. Its enable is term_in[g] when select bit g is 0, and addr_strobe when select bit g is 1.
- R6: A write with cfg_we high and cfg_sel = p (0..2) loads the modes of port p, taking cell bit i's mode from cfg_data[2i+1:2i]. cfg_sel = 3 loads the six select bits from cfg_data[5:0]. The new setting applies from the next cycle.
- R7: When rd_strobe and cs are both high at a clock edge, rd_data after that edge equals bus_out bits of port rd_port as sampled at that edge. rd_port = 3 returns zero.
- R8: When rd_strobe and cs are not both high, rd_data keeps its value.
- R9: Synchronous reset clears every stored cell value and rd_data to zero, sets every mode to 00, and sets every select bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 24 | Port pins, port p at bits 8p+7..8p |
| term_in | input | 6 | Logic-term enable per nibble group |
| addr_strobe | input | 1 | Processor address strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Target: 0..2 mode word of a port, 3 source selects |
| cfg_data | input | 16 | Configuration write data |
| rd_strobe | input | 1 | Processor read strobe |
| cs | input | 1 | Chip select for readback |
| rd_port | input | 2 | Port chosen for readback |
| bus_out | output | 24 | Cell outputs to internal logic |
| rd_data | output | 8 | Registered readback data |

## Verification
On every cycle, the assertions check the following. A latch or register cell whose enable was low at the previous edge keeps its output steady. Readback returns the selected port's bus value from the previous edge, or holds when not addressed. Reset clears the read register.

The directed scenarios cover the rest. They show transparency while an enable is high and capture on an enable's rising edge but not on a level that stays high. They also show the nibble grouping and source choice, and the position of each mode field in a configuration word.

// File: rtl/port_capture_bank.sv
module port_capture_bank #(
  parameter int PORTS = 3,
  parameter int PW    = 8,
  parameter int GRP   = 4,
  localparam int N    = PORTS * PW,
  localparam int NG   = N / GRP,
  localparam int SW   = $clog2(PORTS + 1),
  localparam int DW   = 2 * PW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pin_in,
  input  logic [NG-1:0] term_in,
  input  logic          addr_strobe,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_sel,
  input  logic [DW-1:0] cfg_data,
  input  logic          rd_strobe,
  input  logic          cs,
  input  logic [SW-1:0] rd_port,
  output logic [N-1:0]  bus_out,
  output logic [PW-1:0] rd_data
);

  logic [2*N-1:0] mode_q;
  logic [NG-1:0]  src_q, en_n, en_q;
  logic [N-1:0]   st_q;
  logic [PW-1:0]  rd_sel;

  assign en_n = (src_q & {NG{addr_strobe}}) | (~src_q & term_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      src_q  <= '0;
    end else if (cfg_we) begin
      if (32'(cfg_sel) < PORTS) mode_q[32'(cfg_sel)*DW +: DW] <= cfg_data;
      else                      src_q <= cfg_data[NG-1:0];
    end
  end

  always_ff @(posedge clk) en_q <= rst ? '0 : en_n;

  for (genvar k = 0; k < N; k++) begin : g_cell
    localparam int G = k / GRP;
    logic [1:0] m;
    logic cap;
    assign m   = mode_q[2*k +: 2];
    assign cap = (m == 2'b01 && en_n[G]) || (m == 2'b10 && en_n[G] && !en_q[G]);

    always_ff @(posedge clk) begin
      if (rst)      st_q[k] <= 1'b0;
      else if (cap) st_q[k] <= pin_in[k];
    end

    assign bus_out[k] = (m == 2'b01) ? (en_n[G] ? pin_in[k] : st_q[k]) :
                        (m == 2'b10) ? st_q[k] : pin_in[k];
  end

  always_comb begin
    rd_sel = '0;
    for (int p = 0; p < PORTS; p++)
      if (32'(rd_port) == p) rd_sel = bus_out[p*PW +: PW];
  end

  always_ff @(posedge clk) begin
    if (rst)                   rd_data <= '0;
    else if (rd_strobe && cs) rd_data <= rd_sel;
  end

endmodule

module pcb_checker #(
  parameter int N  = 24,
  parameter int NG = 6,
  parameter int PW = 8,
  parameter int SW = 2,
  parameter int GRP = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  bus_out,
  input logic [2*N-1:0] mode_q,
  input logic [NG-1:0] en_n,
  input logic          rd_strobe,
  input logic          cs,
  input logic [SW-1:0] rd_port,
  input logic [PW-1:0] rd_data
);

  for (genvar k = 0; k < N; k++) begin : g_chk
    localparam int G = k / GRP;
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mode_q[2*k +: 2] == 2'b01 && $past(mode_q[2*k +: 2]) == 2'b01 && !en_n[G] && !$past(en_n[G]) && !$past(rst))
      |-> $stable(bus_out[k])); // R3
    AST_REG_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
      (mode_q[2*k +: 2] == 2'b10 && $past(mode_q[2*k +: 2]) == 2'b10 && !$past(en_n[G]) && !$past(rst))
      |-> $stable(bus_out[k])); // R4
  end

  AST_READ_DATA: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && cs) |=> rd_data == PW'($past(bus_out >> (32'(rd_port) * PW)))); // R7
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(rd_strobe && cs) |=> $stable(rd_data)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rd_data == '0); // R9

endmodule

bind port_capture_bank pcb_checker #(.N(N), .NG(NG), .PW(PW), .SW(SW), .GRP(GRP)) chk_i (
  .clk(clk), .rst(rst), .bus_out(bus_out), .mode_q(mode_q), .en_n(en_n),
  .rd_strobe(rd_strobe), .cs(cs), .rd_port(rd_port), .rd_data(rd_data)
);

// File: tb/port_capture_bank_tb.sv
module port_capture_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] pin_in = '0;
  logic [5:0]  term_in = '0;
  logic        addr_strobe = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_data = '0;
  logic        rd_strobe = 1'b0;
  logic        cs = 1'b0;
  logic [1:0]  rd_port = '0;
  logic [23:0] bus_out;
  logic [7:0]  rd_data;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  port_capture_bank dut_i (
    .clk(clk), .rst(rst), .pin_in(pin_in), .term_in(term_in), .addr_strobe(addr_strobe),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data), .rd_strobe(rd_strobe),
    .cs(cs), .rd_port(rd_port), .bus_out(bus_out), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [15:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; pin_in = 24'h3C_A5_96;
    cyc(); cyc();
    rst = 1'b0; cyc();
    chk("R9 rd_data cleared", rd_data, 0);
    chk("R9 modes back to pass", bus_out, 24'h3C_A5_96);
  endtask

  task automatic t_pass();
    pin_in = 24'h12_34_56; #1;
    chk("R1 R2 pass layout", bus_out, 24'h12_34_56);
    cfg(2'd1, 16'hFFFF);
    pin_in = 24'hE7_81_18; #1;
    chk("R2 mode 11 as pass", bus_out, 24'hE7_81_18);
    cfg(2'd1, 16'h0000);
  endtask

  task automatic t_latch();
    cfg(2'd0, 16'h5555);
    pin_in[7:0] = 8'hA5; #1;
    chk("R3 latch closed shows reset store", bus_out[7:0], 0);
    term_in[0] = 1'b1; #1;
    chk("R3 R5 low nibble transparent", bus_out[7:0], 8'h05);
    pin_in[7:0] = 8'h3C; #1;
    chk("R3 follows pin while open", bus_out[7:0], 8'h0C);
    cyc();
    term_in[0] = 1'b0; pin_in[7:0] = 8'h00; #1;
    chk("R3 holds value of last open edge", bus_out[7:0], 8'h0C);
    cyc();
    chk("R3 hold after further edge", bus_out[7:0], 8'h0C);
  endtask

  task automatic t_reg();
    cfg(2'd1, 16'hAAAA);
    cfg(2'd3, 16'h0004);
    pin_in[15:8] = 8'h96; cyc();
    chk("R4 no capture without edge", bus_out[15:8], 0);
    addr_strobe = 1'b1; #1;
    chk("R4 register not transparent", bus_out[15:8], 0);
    cyc();
    chk("R4 R5 strobe edge captures low nibble", bus_out[15:8], 8'h06);
    pin_in[15:8] = 8'h5A; cyc();
    chk("R4 steady high enable no capture", bus_out[15:8], 8'h06);
    addr_strobe = 1'b0; cyc();
    addr_strobe = 1'b1; cyc();
    chk("R4 second rising edge captures", bus_out[15:8], 8'h0A);
    term_in[3] = 1'b1; cyc();
    chk("R5 term source for high nibble", bus_out[15:8], 8'h5A);
    term_in[3] = 1'b0; addr_strobe = 1'b0;
  endtask

  task automatic t_field();
    cfg(2'd2, 16'h0800);
    pin_in[23:16] = 8'hFF; #1;
    chk("R6 cell 5 field bits 11:10", bus_out[23:16], 8'hDF);
  endtask

  task automatic t_read();
    rd_strobe = 1'b1; cs = 1'b1; rd_port = 2'd2; cyc();
    chk("R7 read port 2", rd_data, 8'hDF);
    rd_port = 2'd3; cyc();
    chk("R7 port 3 reads zero", rd_data, 0);
    rd_port = 2'd0; cyc();
    chk("R7 read latched port 0", rd_data, 8'h0C);
    cs = 1'b0; rd_port = 2'd2; cyc();
    chk("R8 no select holds", rd_data, 8'h0C);
    cs = 1'b1; rd_strobe = 1'b0; cyc();
    chk("R8 no strobe holds", rd_data, 8'h0C);
  endtask

  task automatic t_rst_again();
    rd_strobe = 1'b1; cs = 1'b1; rd_port = 2'd1; cyc();
    rst = 1'b1; rd_strobe = 1'b0; cs = 1'b0; cyc();
    rst = 1'b0; pin_in = 24'h0F_F0_55; cyc();
    chk("R9 rd_data zero after reset", rd_data, 0);
    chk("R9 all cells pass after reset", bus_out, 24'h0F_F0_55);
    cfg(2'd1, 16'hAAAA); #1;
    chk("R9 register stores cleared", bus_out[15:8], 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_pass();
    t_latch();
    t_reg();
    t_field();
    t_read();
    t_rst_again();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule